// File: doc/BRIEF.md
# Memory LCD Serial Update Controller

This block drives a monochrome memory-in-pixel LCD over a write-only serial link made of a clock, a data line and an active-high chip select. It builds three kinds of frames on its own. An update frame rewrites a range of whole rows, and the controller fetches each pixel from an external line buffer through a simple row/column read port that answers in the same cycle. An all-clear frame blanks the panel. A hold frame keeps the image and flips the panel's common-electrode polarity bit so that no DC bias builds up in the liquid crystal.

Update and clear commands arrive as one-cycle pulses. A request that arrives while a frame is being sent is held until the frame ends, and pending update ranges are merged. An internal timer can inject hold frames at a fixed period. The panel-enable request input is a level. Each change of that level first produces a clear frame, and the display-enable output follows only after that frame has been sent.

Top module: `mlcd_link_ctrl`

## Requirements
- R1: The first byte of every frame is the mode byte: the command code (hold = 0, update = 1, clear = 4) with the current polarity bit ORed in at bit position 1.
- R2: Every byte is shifted out least significant bit first. Each bit is valid on the rising edge of `sclk_o`.
- R3: An update frame sends, for each row in ascending order, an 8-bit row address, then `WIDTH` pixel bits from column 0 upward, then 8 zero bits. Its length is 8 + (16 + `WIDTH`) × rows bits.
- R4: The row address sent for row index r is r + 1.
- R5: Clear and hold frames are exactly 16 bits long: the mode byte followed by a zero byte.
- R6: An update covers the inclusive row range between its two indices, given in either order. An index above `HEIGHT`-1 is treated as `HEIGHT`-1. Update requests that are pending together are merged into the smallest range that covers all of them.
- R7: Requests that arrive during a frame are held. When the link is free they are served in the order clear, then update, then hold.
- R8: Any change of `panel_en_i` causes a clear frame first. `disp_en_o` takes the new level only after that frame has completed.
- R9: While `hold_en_i` is high, every `HOLD_CYCLES` clocks the polarity bit flips and a hold frame carrying the new value is issued. Update and clear frames carry the polarity bit in force when they are granted.
- R10: `cs_o` stays high for the whole frame. `sclk_o` toggles only while `cs_o` is high and idles low. `mosi_o` does not change while `sclk_o` is high. Between frames `cs_o` stays low for at least 2×`SCLK_HALF` clocks.
- R11: `busy_o` is high exactly while `cs_o` is high. `done_o` is a single-cycle pulse after each frame.
- R12: After reset, `cs_o`, `sclk_o`, `mosi_o`, `busy_o`, `done_o` and `disp_en_o` are all low and the polarity bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_en_i | input | 1 | Enables the periodic polarity-flip hold frames |
| panel_en_i | input | 1 | Requested panel enable level |
| clr_req_i | input | 1 | One-cycle clear request |
| upd_req_i | input | 1 | One-cycle update request |
| upd_row_a_i | input | 8 | First range index of the update |
| upd_row_b_i | input | 8 | Second range index of the update |
| rd_row_o | output | $clog2(HEIGHT) | Line-buffer read row |
| rd_col_o | output | $clog2(WIDTH) | Line-buffer read column |
| rd_pix_i | input | 1 | Pixel at (rd_row_o, rd_col_o), same cycle |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data |
| cs_o | output | 1 | Chip select, active high |
| disp_en_o | output | 1 | Display enable |
| busy_o | output | 1 | A frame is on the link |
| done_o | output | 1 | One-cycle pulse after each frame |

## Verification
A wrong field counter or bit index shows up inside the very frame it corrupts. The bit stream seen at the rising edges of `sclk_o` will have the wrong length or a wrong mode, address or pixel bit, and that is visible as soon as `cs_o` falls. An arbitration or merge fault appears as a frame out of order, or with the wrong row range, in the frame that follows the one in progress. A polarity fault appears as a wrong bit 1 of the mode byte in the next hold or update frame. Enable tracking is checked at the `disp_en_o` pin while the clear frame is still in progress and again just after `done_o`.

// File: rtl/mlcd_pkg.sv
package mlcd_pkg;

  typedef enum logic [2:0] {
    CMD_HOLD = 3'd0,
    CMD_UPD  = 3'd1,
    CMD_CLR  = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    F_MODE,
    F_ADDR,
    F_PIX,
    F_TAIL
  } fld_e;

  // mode byte: command code with polarity bit at position 1
  function automatic logic [7:0] mode_byte(cmd_e c, logic v);
    return {5'd0, c} | {6'd0, v, 1'b0};
  endfunction

  // row index to on-wire address (one-based)
  function automatic logic [7:0] row_code(logic [7:0] r);
    return r + 8'd1;
  endfunction

endpackage

// File: rtl/mlcd_hold_timer.sv
module mlcd_hold_timer #(
  parameter int unsigned PERIOD = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = $clog2(PERIOD + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (!run_i) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(PERIOD - 1)) begin
        cnt_q  <= '0;
        tick_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r9_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> $past(run_i));

endmodule

// File: rtl/mlcd_req_arb.sv
module mlcd_req_arb
  import mlcd_pkg::*;
#(
  parameter int HEIGHT = 240,
  parameter int ROW_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_req_i,
  input  logic [7:0]       upd_a_i,
  input  logic [7:0]       upd_b_i,
  input  logic             clr_req_i,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             done_i,
  output logic             gnt_o,
  output cmd_e             gnt_cmd_o,
  output logic [ROW_W-1:0] gnt_lo_o,
  output logic [ROW_W-1:0] gnt_hi_o,
  output logic             gnt_vcom_o,
  output logic             disp_en_o
);

  function automatic logic [ROW_W-1:0] clampr(input logic [7:0] x);
    if (x > 8'(HEIGHT - 1)) return ROW_W'(HEIGHT - 1);
    else return x[ROW_W-1:0];
  endfunction

  logic             pend_clr, pend_upd, pend_hold, inflight, vcom_q;
  logic             en_q, tgt_pend, tgt_val, armed, arm_val;
  logic [ROW_W-1:0] lo_q, hi_q;
  logic [ROW_W-1:0] a_c, b_c, rlo, rhi;
  logic             take_clr, take_upd, take_hold, take_any, en_chg;

  always_comb begin
    a_c       = clampr(upd_a_i);
    b_c       = clampr(upd_b_i);
    rlo       = (a_c < b_c) ? a_c : b_c;
    rhi       = (a_c < b_c) ? b_c : a_c;
    en_chg    = en_i != en_q;
    take_clr  = !inflight && pend_clr;
    take_upd  = !inflight && !pend_clr && pend_upd;
    take_hold = !inflight && !pend_clr && !pend_upd && pend_hold;
    take_any  = take_clr || take_upd || take_hold;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_clr   <= 1'b0;
      pend_upd   <= 1'b0;
      pend_hold  <= 1'b0;
      inflight   <= 1'b0;
      vcom_q     <= 1'b0;
      en_q       <= 1'b0;
      tgt_pend   <= 1'b0;
      tgt_val    <= 1'b0;
      armed      <= 1'b0;
      arm_val    <= 1'b0;
      lo_q       <= '0;
      hi_q       <= '0;
      gnt_o      <= 1'b0;
      gnt_cmd_o  <= CMD_HOLD;
      gnt_lo_o   <= '0;
      gnt_hi_o   <= '0;
      gnt_vcom_o <= 1'b0;
      disp_en_o  <= 1'b0;
    end else begin
      gnt_o <= 1'b0;
      en_q  <= en_i;
      if (tick_i) vcom_q <= ~vcom_q;

      pend_clr  <= (pend_clr && !take_clr) || clr_req_i || en_chg;
      pend_hold <= (pend_hold && !take_hold) || tick_i;

      if (en_chg) begin
        tgt_pend <= 1'b1;
        tgt_val  <= en_i;
      end else if (take_clr) begin
        tgt_pend <= 1'b0;
      end

      if (upd_req_i) begin
        pend_upd <= 1'b1;
        if (pend_upd && !take_upd) begin
          lo_q <= (rlo < lo_q) ? rlo : lo_q;
          hi_q <= (rhi > hi_q) ? rhi : hi_q;
        end else begin
          lo_q <= rlo;
          hi_q <= rhi;
        end
      end else if (take_upd) begin
        pend_upd <= 1'b0;
      end

      if (take_any) begin
        gnt_o      <= 1'b1;
        inflight   <= 1'b1;
        gnt_lo_o   <= lo_q;
        gnt_hi_o   <= hi_q;
        gnt_vcom_o <= vcom_q;
        gnt_cmd_o  <= take_clr ? CMD_CLR : (take_upd ? CMD_UPD : CMD_HOLD);
        if (take_clr) begin
          armed   <= tgt_pend;
          arm_val <= tgt_val;
        end
      end

      if (done_i) begin
        inflight <= 1'b0;
        armed    <= 1'b0;
        if (armed) disp_en_o <= arm_val;
      end
    end
  end

  a_r7_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o && gnt_cmd_o != CMD_CLR) |-> !$past(pend_clr));

  a_r7_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_o |-> !$past(inflight));

  a_r8_en_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en_o != $past(disp_en_o)) |-> $past(done_i));

endmodule

// File: rtl/mlcd_frame_eng.sv
module mlcd_frame_eng
  import mlcd_pkg::*;
#(
  parameter int WIDTH  = 400,
  parameter int HEIGHT = 240,
  parameter int ROW_W  = 8,
  parameter int COL_W  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gnt_i,
  input  cmd_e             cmd_i,
  input  logic [ROW_W-1:0] lo_i,
  input  logic [ROW_W-1:0] hi_i,
  input  logic             vcom_i,
  input  logic             take_i,
  input  logic             rd_pix_i,
  output logic             start_o,
  output logic             bit_o,
  output logic             last_o,
  output logic [ROW_W-1:0] rd_row_o,
  output logic [COL_W-1:0] rd_col_o
);
  localparam int BW = $clog2((WIDTH > 8) ? WIDTH : 8);

  cmd_e             cmd_q;
  fld_e             fld_q;
  logic [BW-1:0]    bidx_q;
  logic [ROW_W-1:0] row_q, hi_q;
  logic             vcom_q;
  logic             fld_end, last_row;
  logic [7:0]       mbyte, abyte;

  always_comb begin
    mbyte    = mode_byte(cmd_q, vcom_q);
    abyte    = row_code(8'(row_q));
    last_row = (row_q == hi_q);
    fld_end  = (fld_q == F_PIX) ? (bidx_q == BW'(WIDTH - 1)) : (bidx_q == BW'(7));
    unique case (fld_q)
      F_MODE:  bit_o = mbyte[bidx_q[2:0]];
      F_ADDR:  bit_o = abyte[bidx_q[2:0]];
      F_PIX:   bit_o = rd_pix_i;
      default: bit_o = 1'b0;
    endcase
    last_o = (fld_q == F_TAIL) && fld_end && ((cmd_q != CMD_UPD) || last_row);
  end

  assign rd_row_o = row_q;
  assign rd_col_o = bidx_q[COL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= CMD_HOLD;
      fld_q   <= F_MODE;
      bidx_q  <= '0;
      row_q   <= '0;
      hi_q    <= '0;
      vcom_q  <= 1'b0;
      start_o <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (gnt_i) begin
        cmd_q   <= cmd_i;
        fld_q   <= F_MODE;
        bidx_q  <= '0;
        row_q   <= lo_i;
        hi_q    <= hi_i;
        vcom_q  <= vcom_i;
        start_o <= 1'b1;
      end else if (take_i) begin
        if (!fld_end) begin
          bidx_q <= bidx_q + 1'b1;
        end else begin
          bidx_q <= '0;
          unique case (fld_q)
            F_MODE: fld_q <= (cmd_q == CMD_UPD) ? F_ADDR : F_TAIL;
            F_ADDR: fld_q <= F_PIX;
            F_PIX:  fld_q <= F_TAIL;
            default: begin
              if (cmd_q == CMD_UPD && !last_row) begin
                row_q <= row_q + 1'b1;
                fld_q <= F_ADDR;
              end
            end
          endcase
        end
      end
    end
  end

  a_r4_row_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_q == F_ADDR) |-> (row_q <= hi_q && row_q <= ROW_W'(HEIGHT - 1)));

  a_r5_short_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_UPD) |-> (fld_q == F_MODE || fld_q == F_TAIL));

endmodule

// File: rtl/mlcd_link_pacer.sv
module mlcd_link_pacer #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic bit_i,
  input  logic last_i,
  output logic take_o,
  output logic sclk_o,
  output logic mosi_o,
  output logic cs_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW   = $clog2(2 * HALF + 1);
  localparam int LMAX = 4 * HALF;
  localparam int LW   = $clog2(LMAX + 1);

  typedef enum logic [1:0] {P_IDLE, P_LOW, P_HIGH, P_GAP} pst_e;

  pst_e          st_q;
  logic [CW-1:0] cnt_q;
  logic [LW-1:0] lowcnt_q;
  logic          last_q, half_end, gap_end;

  always_comb begin
    half_end = (cnt_q == CW'(HALF - 1));
    gap_end  = (cnt_q == CW'(2 * HALF - 1));
    take_o   = (st_q == P_IDLE && start_i) || (st_q == P_HIGH && half_end && !last_q);
  end

  assign busy_o = cs_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= P_IDLE;
      cnt_q  <= '0;
      last_q <= 1'b0;
      sclk_o <= 1'b0;
      mosi_o <= 1'b0;
      cs_o   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        P_IDLE: if (start_i) begin
          cs_o   <= 1'b1;
          mosi_o <= bit_i;
          last_q <= last_i;
          cnt_q  <= '0;
          st_q   <= P_LOW;
        end
        P_LOW: if (half_end) begin
          sclk_o <= 1'b1;
          cnt_q  <= '0;
          st_q   <= P_HIGH;
        end else cnt_q <= cnt_q + 1'b1;
        P_HIGH: if (half_end) begin
          sclk_o <= 1'b0;
          cnt_q  <= '0;
          if (last_q) begin
            cs_o   <= 1'b0;
            mosi_o <= 1'b0;
            st_q   <= P_GAP;
          end else begin
            mosi_o <= bit_i;
            last_q <= last_i;
            st_q   <= P_LOW;
          end
        end else cnt_q <= cnt_q + 1'b1;
        default: if (gap_end) begin
          cnt_q  <= '0;
          done_o <= 1'b1;
          st_q   <= P_IDLE;
        end else cnt_q <= cnt_q + 1'b1;
      endcase
    end
  end

  // cycles chip select has been low, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) lowcnt_q <= LW'(LMAX);
    else if (cs_o) lowcnt_q <= '0;
    else if (lowcnt_q != LW'(LMAX)) lowcnt_q <= lowcnt_q + 1'b1;
  end

  a_r10_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> cs_o);

  a_r10_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> $stable(mosi_o));

  a_r10_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_o) |-> (lowcnt_q >= LW'(2 * HALF)));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/mlcd_link_ctrl.sv
module mlcd_link_ctrl
  import mlcd_pkg::*;
#(
  parameter int          WIDTH       = 400,
  parameter int          HEIGHT      = 240,
  parameter int          SCLK_HALF   = 4,
  parameter int unsigned HOLD_CYCLES = 100_000_000,
  localparam int         ROW_W       = (HEIGHT > 1) ? $clog2(HEIGHT) : 1,
  localparam int         COL_W       = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_en_i,
  input  logic             panel_en_i,
  input  logic             clr_req_i,
  input  logic             upd_req_i,
  input  logic [7:0]       upd_row_a_i,
  input  logic [7:0]       upd_row_b_i,
  output logic [ROW_W-1:0] rd_row_o,
  output logic [COL_W-1:0] rd_col_o,
  input  logic             rd_pix_i,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             cs_o,
  output logic             disp_en_o,
  output logic             busy_o,
  output logic             done_o
);

  generate
    if (HEIGHT < 1 || HEIGHT > 255) begin : g_bad_height
      $error("HEIGHT must fit the 8-bit one-based row address");
    end
    if (WIDTH < 8 || (WIDTH % 8) != 0) begin : g_bad_width
      $error("WIDTH must be a non-zero multiple of 8");
    end
  endgenerate

  logic             tick, gnt, gnt_vcom, start, ebit, elast, take;
  cmd_e             gnt_cmd;
  logic [ROW_W-1:0] gnt_lo, gnt_hi;

  mlcd_hold_timer #(.PERIOD(HOLD_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(hold_en_i), .tick_o(tick)
  );

  mlcd_req_arb #(.HEIGHT(HEIGHT), .ROW_W(ROW_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .upd_req_i(upd_req_i), .upd_a_i(upd_row_a_i), .upd_b_i(upd_row_b_i),
    .clr_req_i(clr_req_i), .en_i(panel_en_i), .tick_i(tick), .done_i(done_o),
    .gnt_o(gnt), .gnt_cmd_o(gnt_cmd), .gnt_lo_o(gnt_lo), .gnt_hi_o(gnt_hi),
    .gnt_vcom_o(gnt_vcom), .disp_en_o(disp_en_o)
  );

  mlcd_frame_eng #(.WIDTH(WIDTH), .HEIGHT(HEIGHT), .ROW_W(ROW_W), .COL_W(COL_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .gnt_i(gnt), .cmd_i(gnt_cmd), .lo_i(gnt_lo), .hi_i(gnt_hi), .vcom_i(gnt_vcom),
    .take_i(take), .rd_pix_i(rd_pix_i),
    .start_o(start), .bit_o(ebit), .last_o(elast),
    .rd_row_o(rd_row_o), .rd_col_o(rd_col_o)
  );

  mlcd_link_pacer #(.HALF(SCLK_HALF)) u_pacer (
    .clk(clk), .rst_n(rst_n),
    .start_i(start), .bit_i(ebit), .last_i(elast),
    .take_o(take), .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_o(cs_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  a_r11_done_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !cs_o);

endmodule

// File: tb/mlcd_link_ctrl_bench.sv
module mlcd_link_ctrl_bench;
  localparam int W = 16, H = 6, HALF = 2, HOLD = 4000;
  localparam int RW = $clog2(H), CWD = $clog2(W);

  logic clk = 0, rst_n = 0;
  logic hold_en = 0, panel_en = 0, clr_req = 0, upd_req = 0;
  logic [7:0] ra = 0, rb = 0;
  logic [RW-1:0] rd_row;
  logic [CWD-1:0] rd_col;
  logic rd_pix, sclk, mosi, cs, disp_en, busy, done;
  int pat = 0;

  always #5 clk = ~clk;

  function automatic logic pixf(int r, int c, int p);
    return (((r * 5 + c * 3 + p) % 7) < 3) ^ (((c + p) & 4) != 0);
  endfunction

  assign rd_pix = pixf(int'(rd_row), int'(rd_col), pat);

  mlcd_link_ctrl #(.WIDTH(W), .HEIGHT(H), .SCLK_HALF(HALF), .HOLD_CYCLES(HOLD)) u_mlcd_link_ctrl (
    .clk(clk), .rst_n(rst_n), .hold_en_i(hold_en), .panel_en_i(panel_en),
    .clr_req_i(clr_req), .upd_req_i(upd_req), .upd_row_a_i(ra), .upd_row_b_i(rb),
    .rd_row_o(rd_row), .rd_col_o(rd_col), .rd_pix_i(rd_pix),
    .sclk_o(sclk), .mosi_o(mosi), .cs_o(cs), .disp_en_o(disp_en),
    .busy_o(busy), .done_o(done)
  );

  int checks = 0, fails = 0;
  logic [255:0] fr_bits [0:31];
  int fr_len [0:31];
  int fcnt = 0;
  logic [255:0] cur = 0;
  int cur_n = 0;
  logic sclk_p = 0, cs_p = 0, done_p = 0;
  int lowrun = 100, gap_bad = 0, busy_bad = 0, done_bad = 0;
  int cyc = 0;

  // link monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy !== cs) busy_bad++;
      if (done && done_p) done_bad++;
      if (cs && !cs_p && lowrun < 2 * HALF) gap_bad++;
      if (cs && sclk && !sclk_p && cur_n < 256) begin
        cur[cur_n] = mosi;
        cur_n++;
      end
      if (!cs && cs_p) begin
        fr_bits[fcnt % 32] = cur;
        fr_len[fcnt % 32]  = cur_n;
        fcnt++;
        cur = 0;
        cur_n = 0;
      end
      lowrun = cs ? 0 : lowrun + 1;
    end
    sclk_p = sclk; cs_p = cs; done_p = done;
  end

  task automatic finish_run();
    checks += 3;
    if (gap_bad != 0) begin fails++; $display("FAIL R10 short cs gap count act=%0d exp=0", gap_bad); end
    if (busy_bad != 0) begin fails++; $display("FAIL R11 busy/cs mismatch cycles act=%0d exp=0", busy_bad); end
    if (done_bad != 0) begin fails++; $display("FAIL R11 long done pulse act=%0d exp=0", done_bad); end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=%0d exp<=150000 cycles", cyc);
      finish_run();
    end
  end

  function automatic logic [255:0] exp_short(int code, bit v, output int n);
    logic [255:0] e = 0;
    e[0] = code[0]; e[1] = v; e[2] = code[2];
    n = 16;
    return e;
  endfunction

  function automatic logic [255:0] exp_upd(int lo, int hi, bit v, int p, output int n);
    logic [255:0] e = 0;
    int k = 8;
    e[0] = 1'b1; e[1] = v;
    for (int r = lo; r <= hi; r++) begin
      for (int i = 0; i < 8; i++) e[k + i] = ((r + 1) >> i) & 1;
      k += 8;
      for (int c = 0; c < W; c++) begin e[k] = pixf(r, c, p); k++; end
      k += 8;
    end
    n = k;
    return e;
  endfunction

  function automatic int clampb(int x);
    return (x > H - 1) ? H - 1 : x;
  endfunction

  task automatic chk_frame(int idx, logic [255:0] e, int n, string tag);
    logic [255:0] m = (256'd1 << n) - 1;
    checks++;
    if (fr_len[idx % 32] != n || (fr_bits[idx % 32] & m) != e) begin
      fails++;
      $display("FAIL %s frame %0d len act=%0d exp=%0d bits act=%h exp=%h",
               tag, idx, fr_len[idx % 32], n, fr_bits[idx % 32] & m, e);
    end
  endtask

  task automatic chk1(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin fails++; $display("FAIL %s act=%0b exp=%0b", tag, act, exp); end
  endtask

  task automatic pulse_upd(int a, int b);
    @(negedge clk); upd_req = 1; ra = 8'(a); rb = 8'(b);
    @(negedge clk); upd_req = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_req = 1;
    @(negedge clk); clr_req = 0;
  endtask

  task automatic settle();
    repeat (4 * HALF + 10) @(negedge clk);
  endtask

  bit ev = 0;

  task automatic run_upd(int a, int b, int p, string tag);
    int k, n, lo, hi;
    logic [255:0] e;
    pat = p;
    k = fcnt;
    pulse_upd(a, b);
    wait (fcnt > k);
    lo = clampb(a) < clampb(b) ? clampb(a) : clampb(b);
    hi = clampb(a) < clampb(b) ? clampb(b) : clampb(a);
    e = exp_upd(lo, hi, ev, p, n);
    chk_frame(k, e, n, tag);
    settle();
  endtask

  initial begin
    int k, n;
    logic [255:0] e;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    // R12 reset state
    chk1(cs, 0, "R12 cs in reset"); chk1(sclk, 0, "R12 sclk in reset");
    chk1(mosi, 0, "R12 mosi in reset"); chk1(busy, 0, "R12 busy in reset");
    chk1(disp_en, 0, "R12 disp_en in reset"); chk1(done, 0, "R12 done in reset");
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R5 R1 R2 clear frame, polarity 0
    k = fcnt; pulse_clr(); wait (fcnt > k);
    e = exp_short(4, ev, n); chk_frame(k, e, n, "R5 R1 R2 clear frame");
    settle();

    // R8 enable rise
    k = fcnt; @(negedge clk); panel_en = 1;
    wait (busy); @(negedge clk);
    chk1(disp_en, 0, "R8 disp_en held during clear");
    wait (fcnt > k);
    e = exp_short(4, ev, n); chk_frame(k, e, n, "R8 clear on enable rise");
    settle();
    chk1(disp_en, 1, "R8 disp_en after clear");

    // R3 R4 single row and full range
    run_upd(0, 0, 3, "R3 R4 row 0");
    run_upd(0, 5, 11, "R3 full range");
    // R6 reversed and clamped ranges
    run_upd(5, 2, 7, "R6 reversed range");
    run_upd(9, 3, 20, "R6 clamped range");
    run_upd(200, 255, 1, "R6 both above height");

    // R2 R3 random ranges and pixel patterns
    for (int i = 0; i < 8; i++)
      run_upd(int'($urandom % 10), int'($urandom % 10), int'($urandom % 50), "R2 R3 random update");

    // R7 R6 priority and merge while busy
    pat = 5; k = fcnt;
    pulse_upd(0, 5);
    wait (busy);
    pulse_upd(2, 2); pulse_upd(4, 4); pulse_clr();
    wait (fcnt >= k + 3);
    e = exp_upd(0, 5, ev, 5, n); chk_frame(k, e, n, "R7 first frame");
    e = exp_short(4, ev, n); chk_frame(k + 1, e, n, "R7 clear before update");
    e = exp_upd(2, 4, ev, 5, n); chk_frame(k + 2, e, n, "R6 merged pending range");
    settle();

    // R9 hold timer, polarity flip, update before hold
    pat = 9;
    @(negedge clk); hold_en = 1;
    repeat (HOLD - 300) @(negedge clk);
    k = fcnt;
    pulse_upd(0, 5);
    repeat (600) @(negedge clk);
    pulse_upd(1, 1);
    wait (fcnt >= k + 3);
    e = exp_upd(0, 5, ev, 9, n); chk_frame(k, e, n, "R9 update before tick");
    ev = ~ev;
    e = exp_upd(1, 1, ev, 9, n); chk_frame(k + 1, e, n, "R7 R9 update ahead of hold");
    e = exp_short(0, ev, n); chk_frame(k + 2, e, n, "R9 R5 hold frame flipped");
    wait (fcnt >= k + 4);
    ev = ~ev;
    e = exp_short(0, ev, n); chk_frame(k + 3, e, n, "R9 R1 second hold frame");
    @(negedge clk); hold_en = 0;
    settle();

    // R8 enable fall
    k = fcnt; @(negedge clk); panel_en = 0;
    wait (busy); @(negedge clk);
    chk1(disp_en, 1, "R8 disp_en kept during clear");
    wait (fcnt > k);
    e = exp_short(4, ev, n); chk_frame(k, e, n, "R8 clear on enable fall");
    settle();
    chk1(disp_en, 0, "R8 disp_en after fall");

    finish_run();
  end

endmodule